// File: doc/BRIEF.md
# Serial Character Receiver with Decode Sequencer

This block takes an asynchronous serial line that idles high, finds the falling edge of each start bit and samples the following bits at their centres. It builds each character into a parallel buffer, least significant bit first. It also steps a downstream command decoder through three timed pulses, one per bit period. First the decoder's command register is cleared. Then the finished character is written into the buffer. Last, the decoder is told to latch its outputs. The same counter that counts the received bits drives all three pulses.

The bit rate comes from the block's own clock. A divider of `DIV` cycles gives one sample tick per bit period. The default of 1600 suits a 480 kHz reference clock and a 300 bit/s line. When a start edge is seen, the divider is restarted at half a period. The start bit is then checked again at its centre, so a short low glitch on an idle line is dropped. No parity is checked.

The buffer and the three pulses form a plain push interface with no back-pressure. The buffer keeps its value until the next character overwrites it. Each character therefore stays readable for at least one full frame after its load pulse. A consumer that needs the data longer must copy it on the load pulse. A bad stop bit raises a framing flag, but the character is still delivered.

Top module: `serial_rx_decode`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `rx_buf` is 0 and `dec_clr`, `buf_load`, `dec_fire` and `frm_err` are all 0.
- R2: A line held at 1 produces no pulse on `dec_clr`, `buf_load` or `dec_fire`.
- R3: A low pulse on an idle line that ends before half a bit period has passed is rejected. It produces no pulse, and a later valid frame is still received correctly.
- R4: A frame is one start bit (0), 8 data bits sent least significant bit first, and one stop bit. After the frame, `rx_buf[0]` holds the first data bit received and `rx_buf[7]` holds the last.
- R5: `dec_clr` is a one-cycle pulse raised when the 7th data bit has been sampled. It comes exactly `DIV` cycles before `buf_load`.
- R6: `buf_load` is a one-cycle pulse raised when the 8th data bit has been sampled. `rx_buf` takes the new character in that same cycle and changes at no other time.
- R7: `dec_fire` is a one-cycle pulse exactly `DIV` cycles after `buf_load`, at the centre of the stop bit. The bit counter then returns to idle, and a start bit that follows at once is accepted.
- R8: In the cycle of `dec_fire`, `frm_err` becomes 1 if the stop bit was sampled as 0 and becomes 0 otherwise. It holds that value until the next `dec_fire`. The character is delivered in both cases.
- R9: The bit period is `DIV` clock cycles. The pulses of one frame are spaced by exactly that period.
- R10: Frames sent back to back, each with one stop bit and no idle time between them, are each decoded once and in order.
- R11: No parity is computed. Every 8-bit value, including 0x00 and 0xFF, is delivered unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; `DIV` cycles make one bit period |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Asynchronous serial line, idles at 1 |
| rx_buf | output | DATA_W | Last character received |
| dec_clr | output | 1 | One-cycle pulse that clears the decoder's command register |
| buf_load | output | 1 | One-cycle strobe; `rx_buf` holds the new character in this cycle |
| dec_fire | output | 1 | One-cycle pulse that tells the decoder to latch its outputs |
| frm_err | output | 1 | The last frame's stop bit was 0; updated with `dec_fire` |

## Verification
The assertions rely on three things about the input. `DIV` is at least 4. Reset is held for more than one clock. `rxd` keeps each bit steady for the whole bit period. The stimulus changes `rxd` only on falling clock edges, in steps of exactly `DIV` cycles. The only exception is the deliberate glitch, which lasts three cycles against a half period of eight, and the idle gap left after each bad-stop frame. The `DIV` used on the bench is small, so that many frames fit in a short run.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b1;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rx_baud.sv
module rx_baud #(
  parameter int DIV = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic rearm,
  output logic tick
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CW'(DIV - 1);
    end else if (rearm) begin
      cnt_q <= CW'(HALF - 1);
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= CW'(DIV - 1);
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);

  // R9: with DIV >= 4 two ticks are never adjacent
  p_tick_gap_r9: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line,
  input  logic              tick,
  output logic              run,
  output logic              rearm,
  output logic [DATA_W-1:0] rx_buf,
  output logic              dec_clr,
  output logic              buf_load,
  output logic              dec_fire,
  output logic              frm_err
);
  localparam int CNT_W   = $clog2(DATA_W + 2);
  localparam int CLR_AT  = DATA_W - 1;
  localparam int LOAD_AT = DATA_W;

  rx_state_e         state_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [DATA_W-1:0] shreg;

  assign cnt_nxt = bit_cnt + 1'b1;
  assign run     = (state_q != ST_IDLE);
  assign rearm   = (state_q == ST_IDLE) && !line;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      rx_buf   <= '0;
      dec_clr  <= 1'b0;
      buf_load <= 1'b0;
      dec_fire <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      dec_clr  <= 1'b0;
      buf_load <= 1'b0;
      dec_fire <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          bit_cnt <= '0;
          if (!line) state_q <= ST_START;
        end
        ST_START: begin
          if (tick) state_q <= line ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          if (tick) begin
            shreg   <= {line, shreg[DATA_W-1:1]};
            bit_cnt <= cnt_nxt;
            if (cnt_nxt == CNT_W'(CLR_AT)) dec_clr <= 1'b1;
            if (cnt_nxt == CNT_W'(LOAD_AT)) begin
              buf_load <= 1'b1;
              rx_buf   <= {line, shreg[DATA_W-1:1]};
              state_q  <= ST_STOP;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            bit_cnt  <= cnt_nxt;
            dec_fire <= 1'b1;
            frm_err  <= !line;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7: the three sequence pulses never overlap
  p_pulse_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec_clr, buf_load, dec_fire}));
  // R5: the decoder clear is a single-cycle pulse
  p_clr_single_r5: assert property (@(posedge clk) disable iff (rst)
    dec_clr |=> !dec_clr);
  // R6: the buffer changes only together with its load strobe
  p_buf_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !buf_load |-> (rx_buf == $past(rx_buf)));
  // R8: the framing flag changes only with the decode trigger
  p_ferr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !dec_fire |-> $stable(frm_err));
  // R7: after the trigger the receiver is back at idle
  p_fire_idle_r7: assert property (@(posedge clk) disable iff (rst)
    dec_fire |-> (state_q == ST_IDLE));
endmodule

// File: rtl/serial_rx_decode.sv
module serial_rx_decode #(
  parameter int DIV         = 1600,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_buf,
  output logic              dec_clr,
  output logic              buf_load,
  output logic              dec_fire,
  output logic              frm_err
);
  logic line_s;
  logic tick;
  logic run;
  logic rearm;

  rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(line_s)
  );

  rx_baud #(.DIV(DIV)) baud_i (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .rearm(rearm),
    .tick (tick)
  );

  rx_frame #(.DATA_W(DATA_W)) frame_i (
    .clk     (clk),
    .rst     (rst),
    .line    (line_s),
    .tick    (tick),
    .run     (run),
    .rearm   (rearm),
    .rx_buf  (rx_buf),
    .dec_clr (dec_clr),
    .buf_load(buf_load),
    .dec_fire(dec_fire),
    .frm_err (frm_err)
  );
endmodule

// File: tb/serial_rx_decode_tb_top.sv
module serial_rx_decode_tb_top;
  localparam int DIV = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [7:0] rx_buf;
  logic       dec_clr, buf_load, dec_fire, frm_err;

  always #5 clk = ~clk;

  serial_rx_decode #(.DIV(DIV), .DATA_W(8), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .rxd(rxd), .rx_buf(rx_buf),
    .dec_clr(dec_clr), .buf_load(buf_load), .dec_fire(dec_fire), .frm_err(frm_err)
  );

  typedef struct packed { logic [7:0] data; logic ferr; } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int n_clr = 0, n_load = 0, n_fire = 0;
  int t_clr = -1000, t_load = -1000;
  int buf_chg = 0;
  logic [7:0] last_buf = 8'h00;
  logic mon_on = 1'b0;
  logic done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic ok, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic stop_bit);
    exp_t e;
    e.data = d;
    e.ferr = !stop_bit;
    exp_q.push_back(e);
    rxd = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (DIV) @(negedge clk);
    end
    rxd = stop_bit;
    repeat (DIV) @(negedge clk);
    rxd = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (!buf_load && rx_buf != last_buf) buf_chg++;
      last_buf = rx_buf;
      if (dec_clr) begin
        n_clr++;
        t_clr = cyc;
      end
      if (buf_load) begin
        n_load++;
        chk("R5", (cyc - t_clr) == DIV, cyc - t_clr, DIV);
        if (exp_q.size() == 0) chk("R10", 1'b0, 0, 1);
        else chk("R4", rx_buf == exp_q[0].data, rx_buf, exp_q[0].data);
        t_load = cyc;
      end
      if (dec_fire) begin
        n_fire++;
        chk("R7", (cyc - t_load) == DIV, cyc - t_load, DIV);
        if (exp_q.size() == 0) chk("R10", 1'b0, 0, 1);
        else begin
          chk("R8", frm_err == exp_q[0].ferr, frm_err, exp_q[0].ferr);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values
    chk("R1", rx_buf == 8'h00, rx_buf, 0);
    chk("R1", {dec_clr, buf_load, dec_fire, frm_err} == 4'b0,
        {dec_clr, buf_load, dec_fire, frm_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {rx_buf, dec_clr, buf_load, dec_fire, frm_err} == 12'h0,
        {rx_buf, dec_clr, buf_load, dec_fire, frm_err}, 0);
    mon_on = 1'b1;

    // R2: idle line
    repeat (5 * DIV) @(negedge clk);
    chk("R2", (n_clr + n_load + n_fire) == 0, n_clr + n_load + n_fire, 0);

    // R3: short glitch rejected
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * DIV) @(negedge clk);
    chk("R3", (n_clr + n_load + n_fire) == 0, n_clr + n_load + n_fire, 0);
    send(8'hA5, 1'b1);
    repeat (2 * DIV) @(negedge clk);
    chk("R3", n_fire == 1, n_fire, 1);

    // R11: extreme and mixed values
    send(8'h00, 1'b1);
    repeat (DIV) @(negedge clk);
    send(8'hFF, 1'b1);
    repeat (DIV) @(negedge clk);
    send(8'h01, 1'b1);
    repeat (DIV) @(negedge clk);
    send(8'h80, 1'b1);
    repeat (2 * DIV) @(negedge clk);
    chk("R11", rx_buf == 8'h80, rx_buf, 8'h80);

    // R8: bad stop bit, character still delivered
    send(8'h3C, 1'b0);
    repeat (3 * DIV) @(negedge clk);
    chk("R8", frm_err == 1'b1, frm_err, 1);
    chk("R8", rx_buf == 8'h3C, rx_buf, 8'h3C);
    send(8'h5A, 1'b1);
    repeat (2 * DIV) @(negedge clk);
    chk("R8", frm_err == 1'b0, frm_err, 0);

    // R10: back-to-back frames
    for (int k = 0; k < 8; k++) send(8'(k * 37 + 11), 1'b1);
    repeat (3 * DIV) @(negedge clk);
    chk("R10", exp_q.size() == 0, exp_q.size(), 0);
    chk("R9", (n_clr == n_load) && (n_load == n_fire) && (n_fire == 15), n_fire, 15);
    chk("R6", buf_chg == 0, buf_chg, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule